// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

A bank of general-purpose 32-bit down-counters, four by default, reached through a single word-addressed read/write port and sharing one interrupt line. A top-level control word holds a global run switch, and a read-only identification word sits beside it. Each channel owns a fixed window of registers: a local run switch, a reload value, a count snapshot, a wrap counter, and interrupt pending, acknowledge and enable registers.

While both run switches are on, a channel decrements once per clock. After it has shown zero for one clock it takes the reload value again, bumps its wrap counter and raises its pending flag. A free-running up-count is obtained by inverting the count value. To read the count coherently, software first reads the wrap counter. That read latches the live count into a snapshot register, and the count register returns this snapshot.

Top module: `timer_bank`

## Requirements
- R1: After reset every register reads zero except the identification word (offset 0x10), which reads the parameter REV_ID, and `irq` is 0.
- R2: Bit 0 of the control word (offset 0x00) is the global run switch. A channel's count changes only while this bit and its own run switch are both 1. Otherwise the count and wrap counter hold.
- R3: Writing the channel config register (offset 0x20+0x20*n) with bit 0 = 1 while the channel's run switch is 0 sets the switch, loads the count from the reload register and zeroes the wrap counter, all at that write's clock edge.
- R4: While running, the count drops by one per clock. From zero the next clock reloads it from the reload register (offset 0x24+0x20*n) and increments the wrap counter modulo 2^32, giving a period of reload+1 clocks.
- R5: A read of the wrap counter (offset 0x2C+0x20*n) returns the wrap count and latches the live count at that clock edge. Reads of the count register (offset 0x28+0x20*n) return that latched value until the next wrap-counter read.
- R6: A wrap sets bit 0 of the pending register (offset 0x30+0x20*n). Writing the acknowledge register (offset 0x34+0x20*n) with bit 0 = 1 clears it, and bit 0 = 0 has no effect. A wrap in the same clock as an acknowledge leaves the flag set.
- R7: `irq` is 1 exactly when some channel has both its pending bit and bit 0 of its interrupt-enable register (offset 0x38+0x20*n) set. An enable of 0 suppresses that channel.
- R8: Reads of unmapped, misaligned (addr[1:0] != 0) or write-only addresses return zero. Writes to the identification, count, wrap-counter and pending registers change nothing.
- R9: Channel n's registers occupy 0x20+0x20*n through 0x38+0x20*n, in 4-byte steps. Channels 0 to 3 decode independently.
- R10: A reload value written while the channel is stopped takes effect on the next off-to-on transition of its run switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| irq | output | 1 | Combined interrupt |

## Verification
A behavioural model of every register, with the same one-operation-per-clock sequencing, predicts each read and the `irq` line on every clock. The bench targets the wrap boundary: a design that reloaded on reaching zero instead of one clock later would show a period one short, and a reload of zero exercises a wrap on every clock. It also targets the snapshot rule: a count register that tracked the live count, or a latch taken one clock late, would give a value that does not match the preceding wrap-counter read. Simultaneous wrap and acknowledge, writes to read-only words, stale reload values after a stop/start, and masked channels with pending flags are driven as well. A wrong priority or decode in any of these shows up as a read or `irq` mismatch.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
   // register index inside a channel window: addr[4:2]
   typedef enum logic [2:0] {
      REG_CFG    = 3'd0,
      REG_RELOAD = 3'd1,
      REG_COUNT  = 3'd2,
      REG_WRAPS  = 3'd3,
      REG_PEND   = 3'd4,
      REG_ACK    = 3'd5,
      REG_ENIRQ  = 3'd6,
      REG_NONE   = 3'd7
   } chan_reg_e;

   localparam int unsigned WIN_LSB  = 5;      // 0x20 stride
   localparam int unsigned CTRL_OFS = 0;
   localparam int unsigned REV_OFS  = 16;
endpackage

// File: rtl/timer_bank_decode.sv
module timer_bank_decode
   import timer_bank_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 8,
   localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [AW-1:0] addr,
   output logic          ctrl_hit,
   output logic          rev_hit,
   output logic          chan_hit,
   output logic [CW-1:0] chan_idx,
   output chan_reg_e     chan_reg
);
   localparam int unsigned WW = AW - WIN_LSB;

   logic [WW-1:0] win;
   logic          aligned;

   assign win      = addr[AW-1:WIN_LSB];
   assign aligned  = (addr[1:0] == 2'b00);
   assign chan_reg = chan_reg_e'(addr[4:2]);
   assign chan_idx = CW'(win - WW'(1));

   assign ctrl_hit = (win == '0) && (addr[WIN_LSB-1:0] == WIN_LSB'(CTRL_OFS));
   assign rev_hit  = (win == '0) && (addr[WIN_LSB-1:0] == WIN_LSB'(REV_OFS));
   assign chan_hit = aligned && (win != '0) && (int'(win) <= int'(NCH))
                     && (chan_reg != REG_NONE);
endmodule

// File: rtl/timer_bank_channel.sv
module timer_bank_channel #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gen_en,
   input  logic          wr_cfg,
   input  logic          wr_reload,
   input  logic          wr_ack,
   input  logic          wr_enirq,
   input  logic          rd_wraps,
   input  logic [DW-1:0] wdata,
   output logic          run_sw,
   output logic [DW-1:0] reload,
   output logic [DW-1:0] snap,
   output logic [DW-1:0] wraps,
   output logic          pend,
   output logic          enirq
);
   logic [DW-1:0] cnt_q;
   logic          run, load, wrap;

   assign run  = gen_en && run_sw;
   assign load = wr_cfg && wdata[0] && !run_sw;
   assign wrap = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_sw <= 1'b0;
         reload <= '0;
         snap   <= '0;
         wraps  <= '0;
         pend   <= 1'b0;
         enirq  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (wr_cfg)    run_sw <= wdata[0];
         if (wr_reload) reload <= wdata;
         if (wr_enirq)  enirq  <= wdata[0];
         if (rd_wraps)  snap   <= cnt_q;
         if (load) begin
            cnt_q <= reload;
            wraps <= '0;
         end else if (run) begin
            if (cnt_q == '0) begin
               cnt_q <= reload;
               wraps <= wraps + DW'(1);
            end else begin
               cnt_q <= cnt_q - DW'(1);
            end
         end
         if (wrap)                     pend <= 1'b1;
         else if (wr_ack && wdata[0])  pend <= 1'b0;
      end
   end

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> ($stable(cnt_q) && $stable(wraps)));
   assert_enable_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(reload) && wraps == '0 && run_sw));
   assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - DW'(1)));
   assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !load) |=> (cnt_q == $past(reload) && wraps == $past(wraps) + DW'(1)));
   assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wraps |=> (snap == $past(cnt_q)));
   assert_wrap_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> pend);
   assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && wdata[0] && !wrap) |=> !pend);
endmodule

// File: rtl/timer_bank.sv
module timer_bank
   import timer_bank_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 8,
   parameter logic [31:0] REV_ID = 32'h0001_0203
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq
);
   localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || NCH + 1 > (1 << (AW - WIN_LSB))) begin : g_bad_nch
      $error("timer_bank: NCH does not fit the address space");
   end
   if (AW < 8) begin : g_bad_aw
      $error("timer_bank: AW must be at least 8");
   end
   if (DW < 2 || DW > 32) begin : g_bad_dw
      $error("timer_bank: DW must be 2..32");
   end

   logic          ctrl_hit, rev_hit, chan_hit;
   logic [CW-1:0] chan_idx;
   chan_reg_e     chan_reg;
   logic          gen_q;
   logic          wr_op, rd_op;

   logic [NCH-1:0] run_v, pend_v, enirq_v;
   logic [DW-1:0]  reload_a [NCH];
   logic [DW-1:0]  snap_a   [NCH];
   logic [DW-1:0]  wraps_a  [NCH];

   assign wr_op = bus_sel && bus_wr;
   assign rd_op = bus_sel && !bus_wr;

   timer_bank_decode #(.NCH(NCH), .AW(AW)) u_dec (
      .addr(bus_addr), .ctrl_hit(ctrl_hit), .rev_hit(rev_hit),
      .chan_hit(chan_hit), .chan_idx(chan_idx), .chan_reg(chan_reg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gen_q <= 1'b0;
      else if (wr_op && ctrl_hit) gen_q <= bus_wdata[0];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = chan_hit && (chan_idx == CW'(i));
      timer_bank_channel #(.DW(DW)) u_ch (
         .clk(clk), .rst_n(rst_n), .gen_en(gen_q),
         .wr_cfg   (wr_op && sel && chan_reg == REG_CFG),
         .wr_reload(wr_op && sel && chan_reg == REG_RELOAD),
         .wr_ack   (wr_op && sel && chan_reg == REG_ACK),
         .wr_enirq (wr_op && sel && chan_reg == REG_ENIRQ),
         .rd_wraps (rd_op && sel && chan_reg == REG_WRAPS),
         .wdata(bus_wdata),
         .run_sw(run_v[i]), .reload(reload_a[i]), .snap(snap_a[i]),
         .wraps(wraps_a[i]), .pend(pend_v[i]), .enirq(enirq_v[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_hit) bus_rdata = DW'(gen_q);
      if (rev_hit)  bus_rdata = DW'(REV_ID);
      for (int i = 0; i < NCH; i++) begin
         if (chan_hit && chan_idx == CW'(i)) begin
            case (chan_reg)
               REG_CFG:    bus_rdata = DW'(run_v[i]);
               REG_RELOAD: bus_rdata = reload_a[i];
               REG_COUNT:  bus_rdata = snap_a[i];
               REG_WRAPS:  bus_rdata = wraps_a[i];
               REG_PEND:   bus_rdata = DW'(pend_v[i]);
               REG_ENIRQ:  bus_rdata = DW'(enirq_v[i]);
               default:    bus_rdata = '0;
            endcase
         end
      end
   end

   assign irq = |(pend_v & enirq_v);

   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_op && !ctrl_hit && !rev_hit && !chan_hit) |-> (bus_rdata == '0));
   assert_rev_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_op && rev_hit) |-> (bus_rdata == DW'(REV_ID)));
   assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (enirq_v != '0 && pend_v != '0));
   assert_stopped_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_q && !(wr_op && chan_hit && chan_reg == REG_CFG)) |=> $stable(wraps_a[0]));
endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;
   localparam int NCH = 4;
   localparam logic [31:0] REV = 32'h0001_0203;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int errors = 0, checks = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   timer_bank #(.NCH(NCH), .DW(32), .AW(8), .REV_ID(REV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // ---------------- reference model ----------------
   bit          m_gen;
   bit          m_en [NCH], m_pend [NCH], m_mask [NCH];
   logic [31:0] m_rel [NCH], m_cnt [NCH], m_wr [NCH], m_snap [NCH];

   function automatic logic [7:0] ca(int ch, int idx);
      return 8'(32 * (ch + 1) + 4 * idx);
   endfunction

   function automatic logic [31:0] m_read(logic [7:0] a);
      int ch, idx;
      if (a == 8'h00) return {31'b0, m_gen};
      if (a == 8'h10) return REV;
      if (a[1:0] != 2'b00) return 0;
      ch = int'(a[7:5]) - 1;
      idx = int'(a[4:2]);
      if (ch < 0 || ch >= NCH) return 0;
      case (idx)
         0: return {31'b0, m_en[ch]};
         1: return m_rel[ch];
         2: return m_snap[ch];
         3: return m_wr[ch];
         4: return {31'b0, m_pend[ch]};
         6: return {31'b0, m_mask[ch]};
         default: return 0;
      endcase
   endfunction

   function automatic bit m_irq();
      for (int c = 0; c < NCH; c++) if (m_pend[c] && m_mask[c]) return 1;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gen = 0;
         for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_pend[c] = 0; m_mask[c] = 0;
            m_rel[c] = 0; m_cnt[c] = 0; m_wr[c] = 0; m_snap[c] = 0;
         end
      end else begin
         bit g0;
         g0 = m_gen;
         if (bus_sel && bus_wr && bus_addr == 8'h00) m_gen = bus_wdata[0];
         for (int c = 0; c < NCH; c++) begin
            bit wrapped, en0;
            logic [31:0] cnt0, rel0;
            wrapped = 0; en0 = m_en[c]; cnt0 = m_cnt[c]; rel0 = m_rel[c];
            if (g0 && en0) begin
               if (cnt0 == 0) begin m_cnt[c] = rel0; m_wr[c] = m_wr[c] + 1; wrapped = 1; end
               else m_cnt[c] = cnt0 - 1;
            end
            if (bus_sel && !bus_wr && bus_addr == ca(c, 3)) m_snap[c] = cnt0;
            if (bus_sel && bus_wr) begin
               if (bus_addr == ca(c, 0)) begin
                  m_en[c] = bus_wdata[0];
                  if (bus_wdata[0] && !en0) begin m_cnt[c] = rel0; m_wr[c] = 0; end
               end
               if (bus_addr == ca(c, 1)) m_rel[c] = bus_wdata;
               if (bus_addr == ca(c, 5) && bus_wdata[0]) m_pend[c] = 0;
               if (bus_addr == ca(c, 6)) m_mask[c] = bus_wdata[0];
            end
            if (wrapped) m_pend[c] = 1;
         end
      end
   end

   // irq compared on every clock (R7)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #2;
         checks++;
         if (irq !== m_irq()) begin
            errors++;
            $display("FAIL R7 irq: actual=%0b expected=%0b at %0t", irq, m_irq(), $time);
         end
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(logic [7:0] a, string tag);
      logic [31:0] exp;
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = 0;
      exp = m_read(a);
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s addr=%02h: actual=%08h expected=%08h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic rd_lit(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = 0;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s addr=%02h: actual=%08h expected=%08h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic idle(int n);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      repeat (n - 1) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: reset values, literal expectations
      rd_lit(8'h10, REV, "R1 rev");
      rd_lit(8'h00, 0, "R1 ctrl");
      for (int c = 0; c < NCH; c++) begin
         rd_lit(ca(c, 0), 0, "R1 cfg");
         rd_lit(ca(c, 3), 0, "R1 wraps");
      end

      // R8: unmapped / misaligned / write-only reads
      rd_lit(8'h04, 0, "R8 gap");
      rd_lit(8'h1C, 0, "R8 gap");
      rd_lit(8'h3C, 0, "R8 unmapped slot");
      rd_lit(8'hA0, 0, "R8 beyond last channel");
      rd_lit(8'h21, 0, "R8 misaligned");
      rd_lit(ca(0, 5), 0, "R8 write-only ack");

      // R9: program all channels through their own windows
      wr(ca(0, 1), 32'd5);  wr(ca(0, 6), 1);
      wr(ca(1, 1), 32'hFFFF_FFFF); wr(ca(1, 6), 1);
      wr(ca(2, 1), 32'd7);  wr(ca(2, 6), 0);
      wr(ca(3, 1), 32'd0);  wr(ca(3, 6), 1);
      for (int c = 0; c < NCH; c++) rd(ca(c, 1), "R9 reload readback");
      rd_lit(ca(2, 1), 32'd7, "R9 ch2 reload");
      wr(ca(0, 0), 1); wr(ca(1, 0), 1); wr(ca(2, 0), 1); wr(ca(3, 0), 1);
      // R2: global switch off, nothing moves
      idle(6);
      rd(ca(0, 3), "R2 wraps held"); rd_lit(ca(0, 2), 32'd5, "R2 count held (R3 load)");
      rd(ca(1, 3), "R2"); rd(ca(1, 2), "R2 ch1 count");

      // R4/R5/R6: run
      wr(8'h00, 1);
      idle(1);
      for (int k = 0; k < 30; k++) begin
         int c;
         c = k % NCH;
         rd(ca(c, 3), "R4 wraps");
         rd(ca(c, 2), "R5 snapshot");
         rd(ca(c, 2), "R5 snapshot stable");
         rd(ca(c, 4), "R6 pending");
         if (k % 5 == 0) idle(k % 7 + 1);
      end

      // R6: ack with bit0=0 no effect, bit0=1 clears; ch3 wraps every clock (set wins)
      wr(ca(0, 5), 0); rd(ca(0, 4), "R6 ack0 ignored");
      wr(ca(0, 5), 1); rd(ca(0, 4), "R6 ack clears");
      wr(ca(3, 5), 1); rd(ca(3, 4), "R6 wrap wins over ack");
      wr(ca(2, 5), 1); rd(ca(2, 4), "R6 ch2 ack");
      idle(10); rd(ca(2, 4), "R7 masked pending");

      // R8: writes to read-only words
      wr(8'h10, 32'h1234_5678); rd_lit(8'h10, REV, "R8 rev write ignored");
      wr(ca(0, 2), 32'hDEAD); wr(ca(0, 3), 32'hBEEF); wr(ca(0, 4), 1);
      rd(ca(0, 3), "R8 wraps write ignored"); rd(ca(0, 2), "R8 count write ignored");
      rd(ca(0, 4), "R8 pending write ignored");

      // R10 / R3: stop, new reload, restart
      wr(ca(0, 0), 0); wr(ca(0, 1), 32'd2); idle(3);
      rd(ca(0, 3), "R2 local stop"); rd(ca(0, 2), "R2 local stop count");
      wr(ca(0, 0), 1);
      for (int k = 0; k < 8; k++) begin
         rd(ca(0, 3), "R10 wraps after restart");
         rd(ca(0, 2), "R10 count after restart");
      end
      // re-writing enable while running does not reload
      wr(ca(0, 0), 1); rd(ca(0, 3), "R3 no reload when already on");

      // R2: global stop
      wr(8'h00, 0); idle(4);
      for (int c = 0; c < NCH; c++) begin rd(ca(c, 3), "R2 global stop"); rd(ca(c, 2), "R2 global stop count"); end
      idle(4);
      for (int c = 0; c < NCH; c++) rd(ca(c, 3), "R2 global stop held");

      idle(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule